// File: doc/BRIEF.md
# Bridge Read Prefetch Span Controller

This block sits on the target side of a bus bridge and decides how far a read runs ahead of the initiator. When a read request is accepted, it looks at the read command kind, the starting DWORD address, whether the address lies in prefetchable space, the cache line size setting and whether flow-through mode is enabled. From these it works out a fetch span that ends on the proper aligned boundary. It then issues one sequential DWORD fetch per cycle until the span is used up, the target disconnects early, or the initiator ends the transaction.

Fetched DWORDs are handed to the initiator through a valid/take handshake. The beat that empties a completed fetch is marked as the target-disconnect beat. Fetching pauses whenever the number of fetched but undelivered DWORDs reaches the queue depth. If the initiator ends the transaction while fetched data is still undelivered, the block reports how many DWORDs it dropped in a one-cycle discard pulse and returns to idle.

Top module: `pfb_prefetch_ctrl`

## Requirements
- R1: Command codes are 0 = configuration read, 1 = I/O read, 2 = memory read, 3 = memory read line, 4 = memory read multiple. Codes 0, 1 and the unused codes 5 to 7 fetch exactly one DWORD, whatever the cache line size or mode.
- R2: A memory read (code 2) with the prefetchable flag low fetches exactly one DWORD, with flow-through mode on or off.
- R3: With flow-through off, a prefetchable memory read (code 2, flag high) or a read line (code 3) fetches up to the next 16-DWORD aligned address when the cache line size is 0, 16 or any value other than 1, 2, 4 or 8. The span is 16 minus (start mod 16), so a start already on a boundary gets 16 DWORDs.
- R4: With flow-through off and a cache line size L of 1, 2, 4 or 8, the same commands fetch up to the next L-aligned address: L minus (start mod L) DWORDs.
- R5: With flow-through off, a read multiple (code 4) fetches QDEPTH DWORDs (32 by default) when the cache line size is not 1, 2, 4 or 8. For L of 1, 2, 4 or 8 it fetches to the second line boundary: 2L minus (start mod L) DWORDs.
- R6: With flow-through on, any prefetchable read (code 2 with flag high, code 3, code 4) fetches up to the next 4 KB aligned address: 1024 minus (start mod 1024) DWORDs, unless the initiator ends first.
- R7: Fetch addresses run from the start address upward by one per fetch. At most one fetch is issued per cycle, and fetched-but-undelivered DWORDs never exceed QDEPTH.
- R8: When the target disconnect input is high during a fetch, that fetch is the last of the transaction.
- R9: The disconnect flag accompanies only the delivered beat that empties a completed fetch. After that beat is taken the block returns to idle.
- R10: When the initiator ends an active transaction, no fetch is issued in that cycle or later. The next cycle shows a one-cycle discard pulse whose count equals fetched minus delivered DWORDs, including any beat taken in the ending cycle. The block then returns to idle.
- R11: A request is accepted only while busy is low. A request presented while busy is ignored and does not change the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New read request present |
| req_cmd | input | 3 | Read command code (see R1) |
| req_addr | input | ADDR_W | Start DWORD address |
| req_pref | input | 1 | Address lies in prefetchable space |
| req_cls | input | CLS_W | Cache line size in DWORDs |
| req_flow | input | 1 | Flow-through mode enable |
| busy | output | 1 | Transaction in progress |
| fetch_req | output | 1 | Issue a DWORD fetch this cycle |
| fetch_addr | output | ADDR_W | DWORD address of the fetch |
| tgt_disc | input | 1 | Target disconnects on the current fetch |
| dlv_valid | output | 1 | A fetched DWORD is ready for the initiator |
| dlv_last | output | 1 | This beat carries the target disconnect |
| init_take | input | 1 | Initiator takes the offered beat |
| init_end | input | 1 | Initiator ends the transaction |
| disc_valid | output | 1 | One-cycle pulse: leftover data dropped |
| disc_cnt | output | $clog2(PAGE_DW)+1 | Number of DWORDs dropped |

## Verification
The bench aims at starts that already sit on a line, 16-DWORD or 4 KB boundary. A design that measured the distance to the boundary with the wrong offset would fetch zero DWORDs there, or a whole extra block. It uses cache line sizes outside the legal set and a read multiple with a small line size. A wrong size decode or a missing second line would show up as a span that is too short or too long. It holds the initiator back with random take patterns, so that reaching the queue depth, delivering a beat in the same cycle as an early end, and a target disconnect while fetching is paused all occur. A design that overran the queue, mistimed the disconnect flag or miscounted the dropped DWORDs would be caught in these cases.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        CMD_CFG  = 3'd0,
        CMD_IO   = 3'd1,
        CMD_MEM  = 3'd2,
        CMD_LINE = 3'd3,
        CMD_MULT = 3'd4
    } rd_cmd_e;

endpackage

// File: rtl/pfb_span_calc.sv
module pfb_span_calc #(
    parameter int ADDR_W  = 30,
    parameter int CLS_W   = 8,
    parameter int QDEPTH  = 32,
    parameter int BLK_DW  = 16,
    parameter int PAGE_DW = 1024,
    parameter int LEN_W   = $clog2(PAGE_DW) + 1
) (
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pref,
    input  logic [CLS_W-1:0]  cls,
    input  logic              flow,
    output logic [LEN_W-1:0]  span
);
    import pfb_pkg::*;

    localparam int BLK_LG  = $clog2(BLK_DW);
    localparam int PAGE_LG = $clog2(PAGE_DW);

    logic             small_line;
    logic [LEN_W-1:0] line_dw;
    logic [LEN_W-1:0] blk_off;
    logic [LEN_W-1:0] page_off;
    logic [LEN_W-1:0] line_off;
    logic [LEN_W-1:0] blk_rem;
    logic [LEN_W-1:0] line_rem;
    logic [LEN_W-1:0] page_rem;
    logic             pref_read;
    rd_cmd_e          kind;

    // Legal small line sizes are the powers of two below the block size.
    always_comb begin
        small_line = 1'b0;
        line_dw    = LEN_W'(BLK_DW);
        for (int k = 0; k < BLK_LG; k++) begin
            if (cls == CLS_W'(1 << k)) begin
                small_line = 1'b1;
                line_dw    = LEN_W'(1 << k);
            end
        end
    end

    always_comb begin
        blk_off  = LEN_W'(addr[BLK_LG-1:0]);
        page_off = LEN_W'(addr[PAGE_LG-1:0]);
        line_off = blk_off & (line_dw - LEN_W'(1));
        blk_rem  = LEN_W'(BLK_DW) - blk_off;
        line_rem = line_dw - line_off;
        page_rem = LEN_W'(PAGE_DW) - page_off;
    end

    always_comb begin
        kind      = rd_cmd_e'(cmd);
        pref_read = ((kind == CMD_MEM) && pref) ||
                    (kind == CMD_LINE) || (kind == CMD_MULT);
        span      = LEN_W'(1);
        if (pref_read) begin
            if (flow) begin
                span = page_rem;
            end else if (kind == CMD_MULT) begin
                span = small_line ? (line_rem + line_dw) : LEN_W'(QDEPTH);
            end else begin
                span = small_line ? line_rem : blk_rem;
            end
        end
    end

endmodule

// File: rtl/pfb_fetch_engine.sv
module pfb_fetch_engine #(
    parameter int ADDR_W = 30,
    parameter int QDEPTH = 32,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  span_in,
    input  logic              tgt_disc,
    input  logic              init_end,
    input  logic              txn_done,
    input  logic [LEN_W-1:0]  delivered,
    output logic              active,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [LEN_W-1:0]  fetched,
    output logic              fetch_done
);

    typedef struct packed {
        logic              active;
        logic              stop;
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  span;
        logic [LEN_W-1:0]  fetched;
    } eng_t;

    eng_t eng_d, eng_q;
    logic room;

    always_comb begin
        room       = (eng_q.fetched - delivered) < LEN_W'(QDEPTH);
        fetch_req  = eng_q.active && !eng_q.stop &&
                     (eng_q.fetched != eng_q.span) && room && !init_end;
        fetch_addr = eng_q.start + ADDR_W'(eng_q.fetched);
        fetch_done = eng_q.active &&
                     (eng_q.stop || (eng_q.fetched == eng_q.span));
        active     = eng_q.active;
        fetched    = eng_q.fetched;

        eng_d = eng_q;
        if (!eng_q.active) begin
            if (req_valid) begin
                eng_d.active  = 1'b1;
                eng_d.stop    = 1'b0;
                eng_d.start   = req_addr;
                eng_d.span    = span_in;
                eng_d.fetched = '0;
            end
        end else begin
            if (fetch_req) begin
                eng_d.fetched = eng_q.fetched + LEN_W'(1);
                if (tgt_disc) begin
                    eng_d.stop = 1'b1;
                end
            end
            if (init_end || txn_done) begin
                eng_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assert_no_fetch_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.active |-> !fetch_req);

    assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> ((fetched - delivered) < LEN_W'(QDEPTH)));

    assert_stop_after_disc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && tgt_disc) |=> !fetch_req);

    assert_no_fetch_on_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.active && init_end) |=> !eng_q.active);

endmodule

// File: rtl/pfb_deliver_track.sv
module pfb_deliver_track #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [LEN_W-1:0] fetched,
    input  logic             fetch_done,
    input  logic             init_take,
    input  logic             init_end,
    output logic             dlv_valid,
    output logic             dlv_last,
    output logic             txn_done,
    output logic [LEN_W-1:0] delivered,
    output logic             disc_valid,
    output logic [LEN_W-1:0] disc_cnt
);

    typedef struct packed {
        logic [LEN_W-1:0] delivered;
        logic             disc_valid;
        logic [LEN_W-1:0] disc_cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic beat;

    always_comb begin
        dlv_valid  = active && (trk_q.delivered != fetched);
        dlv_last   = dlv_valid && fetch_done &&
                     ((trk_q.delivered + LEN_W'(1)) == fetched);
        beat       = dlv_valid && init_take;
        txn_done   = beat && dlv_last;
        delivered  = trk_q.delivered;
        disc_valid = trk_q.disc_valid;
        disc_cnt   = trk_q.disc_cnt;

        trk_d            = trk_q;
        trk_d.disc_valid = 1'b0;
        if (active) begin
            if (beat) begin
                trk_d.delivered = trk_q.delivered + LEN_W'(1);
            end
            if (init_end) begin
                trk_d.disc_valid = 1'b1;
                trk_d.disc_cnt   = fetched - trk_q.delivered - LEN_W'(beat);
                trk_d.delivered  = '0;
            end else if (txn_done) begin
                trk_d.delivered = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assert_discard_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && init_end) |=> trk_q.disc_valid);

    assert_last_ends_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && init_take && dlv_last && !init_end) |=> (!active && !trk_q.disc_valid));

    assert_last_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_last |-> fetch_done);

    assert_no_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (trk_q.delivered <= fetched));

endmodule

// File: rtl/pfb_prefetch_ctrl.sv
module pfb_prefetch_ctrl #(
    parameter int ADDR_W  = 30,
    parameter int CLS_W   = 8,
    parameter int QDEPTH  = 32,
    parameter int BLK_DW  = 16,
    parameter int PAGE_DW = 1024,
    localparam int LEN_W  = $clog2(PAGE_DW) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_pref,
    input  logic [CLS_W-1:0]  req_cls,
    input  logic              req_flow,
    output logic              busy,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              tgt_disc,
    output logic              dlv_valid,
    output logic              dlv_last,
    input  logic              init_take,
    input  logic              init_end,
    output logic              disc_valid,
    output logic [LEN_W-1:0]  disc_cnt
);

    logic [LEN_W-1:0] span;
    logic [LEN_W-1:0] fetched;
    logic [LEN_W-1:0] delivered;
    logic             active;
    logic             fetch_done;
    logic             txn_done;

    pfb_span_calc #(
        .ADDR_W (ADDR_W),
        .CLS_W  (CLS_W),
        .QDEPTH (QDEPTH),
        .BLK_DW (BLK_DW),
        .PAGE_DW(PAGE_DW),
        .LEN_W  (LEN_W)
    ) span_i (
        .cmd (req_cmd),
        .addr(req_addr),
        .pref(req_pref),
        .cls (req_cls),
        .flow(req_flow),
        .span(span)
    );

    pfb_fetch_engine #(
        .ADDR_W(ADDR_W),
        .QDEPTH(QDEPTH),
        .LEN_W (LEN_W)
    ) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .span_in   (span),
        .tgt_disc  (tgt_disc),
        .init_end  (init_end),
        .txn_done  (txn_done),
        .delivered (delivered),
        .active    (active),
        .fetch_req (fetch_req),
        .fetch_addr(fetch_addr),
        .fetched   (fetched),
        .fetch_done(fetch_done)
    );

    pfb_deliver_track #(
        .LEN_W(LEN_W)
    ) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .fetched   (fetched),
        .fetch_done(fetch_done),
        .init_take (init_take),
        .init_end  (init_end),
        .dlv_valid (dlv_valid),
        .dlv_last  (dlv_last),
        .txn_done  (txn_done),
        .delivered (delivered),
        .disc_valid(disc_valid),
        .disc_cnt  (disc_cnt)
    );

    assign busy = active;

    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_span_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |-> (span != '0));

endmodule

// File: tb/pfb_prefetch_ctrl_tb_top.sv
module pfb_prefetch_ctrl_tb_top;

    localparam int ADDR_W  = 30;
    localparam int CLS_W   = 8;
    localparam int QDEPTH  = 32;
    localparam int PAGE_DW = 1024;
    localparam int LEN_W   = $clog2(PAGE_DW) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_pref = 1'b0;
    logic [CLS_W-1:0]  req_cls = '0;
    logic              req_flow = 1'b0;
    logic              busy, fetch_req, dlv_valid, dlv_last, disc_valid;
    logic [ADDR_W-1:0] fetch_addr;
    logic [LEN_W-1:0]  disc_cnt;
    logic              tgt_disc = 1'b0;
    logic              init_take = 1'b0;
    logic              init_end = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    pfb_prefetch_ctrl #(
        .ADDR_W(ADDR_W), .CLS_W(CLS_W), .QDEPTH(QDEPTH), .PAGE_DW(PAGE_DW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_pref(req_pref), .req_cls(req_cls),
        .req_flow(req_flow), .busy(busy), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .tgt_disc(tgt_disc), .dlv_valid(dlv_valid),
        .dlv_last(dlv_last), .init_take(init_take), .init_end(init_end),
        .disc_valid(disc_valid), .disc_cnt(disc_cnt)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit legal_small(input int cls);
        return (cls == 1) || (cls == 2) || (cls == 4) || (cls == 8);
    endfunction

    // Expected span, written from the requirements.
    function automatic int exp_span(input int cmd, input int addr, input bit pref,
                                    input int cls, input bit ft);
        bit pr;
        pr = (cmd == 2 && pref) || cmd == 3 || cmd == 4;
        if (!pr) return 1;                                   // R1 / R2
        if (ft) return 1024 - (addr % 1024);                 // R6
        if (cmd == 4) begin                                  // R5
            if (legal_small(cls)) return 2 * cls - (addr % cls);
            return QDEPTH;
        end
        if (legal_small(cls)) return cls - (addr % cls);     // R4
        return 16 - (addr % 16);                             // R3
    endfunction

    function automatic string span_tag(input int cmd, input bit pref, input int cls, input bit ft);
        bit pr;
        pr = (cmd == 2 && pref) || cmd == 3 || cmd == 4;
        if (cmd != 2 && cmd != 3 && cmd != 4) return "R1";
        if (!pr) return "R2";
        if (ft) return "R6";
        if (cmd == 4) return "R5";
        if (legal_small(cls)) return "R4";
        return "R3";
    endfunction

    // disc_at: fetch index carrying the target disconnect (-1 none)
    // end_at : initiator ends once this many beats are delivered (-1 none)
    // poke   : present a second request while busy (R11)
    task automatic run_txn(input int cmd, input int addr, input bit pref, input int cls,
                           input bit ft, input int disc_at, input int end_at, input bit poke);
        int exp, nf, nd, lastcnt, cyc;
        bit early, last_ok, addr_ok, q_ok, ended;
        string tg;
        logic [ADDR_W-1:0] a0;
        exp = exp_span(cmd, addr, pref, cls, ft);
        tg  = span_tag(cmd, pref, cls, ft);
        if (disc_at >= 0 && disc_at + 1 < exp) begin
            exp = disc_at + 1;
            tg  = "R8";
        end
        early = (end_at >= 0) && (end_at < exp);
        a0 = ADDR_W'(addr);
        nf = 0; nd = 0; lastcnt = 0; cyc = 0;
        last_ok = 1'b1; addr_ok = 1'b1; q_ok = 1'b1; ended = 1'b0;

        @(negedge clk);
        req_valid = 1'b1; req_cmd = 3'(cmd); req_addr = a0;
        req_pref = pref; req_cls = CLS_W'(cls); req_flow = ft;
        @(posedge clk);
        forever begin
            @(negedge clk);
            req_valid = poke && (cyc == 2);
            req_cmd   = 3'd4; req_addr = a0 + 30'd7; req_flow = 1'b1; req_cls = 8'd0;
            init_take = ($urandom % 4) != 0;
            tgt_disc  = (disc_at >= 0) && (nf == disc_at);
            init_end  = early && (nd >= end_at);
            #1;
            if (cyc == 0) check(busy === 1'b1, "R11 busy after accept", busy, 1);
            if (fetch_req) begin
                if (fetch_addr !== a0 + ADDR_W'(nf)) addr_ok = 1'b0;
                nf++;
            end
            if (nf - nd > QDEPTH) q_ok = 1'b0;
            if (dlv_valid && init_take) begin
                nd++;
                if (dlv_last) begin
                    lastcnt++;
                    if (nd != exp) last_ok = 1'b0;
                end
            end
            cyc++;
            if (init_end) begin ended = 1'b1; break; end
            if (dlv_valid && init_take && dlv_last) break;
            if (cyc > 6000) break;
        end
        @(negedge clk);
        req_valid = 1'b0; tgt_disc = 1'b0; init_end = 1'b0; init_take = 1'b0;
        #1;
        check(busy === 1'b0, "R11 idle after end", busy, 0);
        check(addr_ok, "R7 sequential fetch addresses", addr_ok, 1);
        check(q_ok, "R7 outstanding within queue depth", q_ok, 1);
        if (early) begin
            check(ended, "R10 end applied", ended, 1);
            check(disc_valid === 1'b1, "R10 discard pulse", disc_valid, 1);
            check(disc_cnt == LEN_W'(nf - nd), "R10 discard count", disc_cnt, nf - nd);
            check(nf <= exp, {tg, " fetch bound on early end"}, nf, exp);
        end else begin
            check(nf == exp, {tg, " fetched DWORDs"}, nf, exp);
            check(nd == exp, {tg, " delivered DWORDs"}, nd, exp);
            check(lastcnt == 1 && last_ok, "R9 disconnect on final beat", lastcnt, 1);
            check(disc_valid === 1'b0, "R9 no discard on full delivery", disc_valid, 0);
        end
    endtask

    initial begin
        int cls_pick [9] = '{0, 1, 2, 4, 8, 16, 3, 32, 255};
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(busy === 1'b0 && fetch_req === 1'b0, "R11 reset idle", busy, 0);
        check(dlv_valid === 1'b0 && disc_valid === 1'b0, "R9 reset no data", dlv_valid, 0);

        // Directed corner cases
        run_txn(0, 5, 1, 8, 0, -1, -1, 0);      // R1 config read
        run_txn(1, 16, 1, 0, 1, -1, -1, 0);     // R1 I/O read, flow-through
        run_txn(6, 3, 1, 4, 0, -1, -1, 0);      // R1 unused code
        run_txn(2, 40, 0, 16, 1, -1, -1, 0);    // R2 non-prefetchable
        run_txn(2, 3, 1, 0, 0, -1, -1, 0);      // R3 -> 13
        run_txn(3, 32, 1, 16, 0, -1, -1, 0);    // R3 on boundary -> 16
        run_txn(2, 33, 1, 7, 0, -1, -1, 0);     // R3 illegal line size -> 15
        run_txn(3, 6, 1, 4, 0, -1, -1, 0);      // R4 -> 2
        run_txn(2, 8, 1, 8, 0, -1, -1, 0);      // R4 on boundary -> 8
        run_txn(4, 9, 1, 0, 0, -1, -1, 0);      // R5 queue depth -> 32
        run_txn(4, 5, 1, 2, 0, -1, -1, 0);      // R5 second line -> 3
        run_txn(4, 16, 0, 8, 0, -1, -1, 0);     // R5 on boundary -> 16
        run_txn(2, 1020, 1, 0, 1, -1, -1, 0);   // R6 -> 4
        run_txn(3, 2048, 1, 4, 1, -1, -1, 0);   // R6 full page -> 1024
        run_txn(4, 100, 1, 0, 1, -1, 40, 0);    // R6/R10 early end
        run_txn(2, 0, 1, 0, 0, 5, -1, 0);       // R8 target disconnect
        run_txn(4, 2, 1, 0, 0, -1, 3, 0);       // R10 discard
        run_txn(3, 0, 1, 0, 0, -1, -1, 1);      // R11 request while busy

        // Constrained random
        for (int i = 0; i < 60; i++) begin
            int cmd, addr, cls, da, ea;
            bit pref, ft;
            cmd  = $urandom % 5;
            addr = $urandom % 8192;
            pref = $urandom % 2;
            cls  = cls_pick[$urandom % 9];
            ft   = ($urandom % 8) == 0;
            da   = (($urandom % 5) == 0) ? int'($urandom % 20) : -1;
            ea   = (($urandom % 5) == 0) ? int'($urandom % 24) : -1;
            run_txn(cmd, addr, pref, cls, ft, da, ea, ($urandom % 6) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule